// File: doc/BRIEF.md
# Interrupt and Speed Control Register File

This block is a small bank of byte-wide control registers that sits on an 8-bit system bus with a 16-bit address. It holds the interrupt-enable mask and a compatibility-mode register. It shows the interrupt flags of five peripherals as one composed byte. It also runs the two-step handshake that moves the system clock between normal and double speed.

The interrupt-flag byte is not stored here. Each of its five low bits is the live request line of one peripheral. A bus write to that byte is sent back to the peripherals as a set pulse and a clear pulse per bit. To change speed, software first arms the switch by writing the speed register. The CPU then raises an execute strobe when it runs its stop instruction. An armed strobe flips the speed, disarms the switch and pulses a change output for the clock logic. Reads are combinational from the address. Writes take effect at the rising clock edge.

Top module: `irq_speed_regs`

## Requirements
- R1: A read of 0xFF0F returns {3'b111, req_in[4:0]}. Bit 0 is vblank, bit 1 is LCD status, bit 2 is timer, bit 3 is serial and bit 4 is joypad.
- R2: In the cycle of a bus write to 0xFF0F, req_set equals wdata[4:0] and req_clr equals ~wdata[4:0]. In every other cycle both are zero.
- R3: 0xFFFF is an 8-bit read/write enable register whose value is driven on irq_enable from the cycle after the write.
- R4: A write to 0xFF4D loads the armed flag from wdata[0].
- R5: A read of 0xFF4D returns {double_speed, 6'b111111, armed}.
- R6: An execute strobe while armed toggles double_speed and clears the armed flag at that edge. speed_changed is high for exactly the following cycle.
- R7: An execute strobe while not armed changes neither the speed nor the armed flag, and it raises no speed_changed pulse.
- R8: 0xFF4C reads back the last byte written. Writing exactly 0x04 sets compat_mode, which then stays high until reset.
- R9: After reset, double_speed, the armed flag, compat_mode, irq_enable and the 0xFF4C register are all zero.
- R10: When an armed execute strobe and a write to 0xFF4D fall in the same cycle, the strobe wins and the armed flag ends clear.
- R11: For any other address, rd_hit is 0, rdata is 0x00, and writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| bus_rd_hit | output | 1 | bus_addr selects a register of this block |
| req_in | input | 5 | Live peripheral request lines |
| req_set | output | 5 | Per-bit request set pulses |
| req_clr | output | 5 | Per-bit request clear pulses |
| irq_enable | output | 8 | Interrupt enable mask |
| spd_exec | input | 1 | Speed-switch execute strobe from the CPU |
| double_speed | output | 1 | 1 while running at double speed |
| speed_changed | output | 1 | One-cycle pulse after a speed toggle |
| compat_mode | output | 1 | Sticky compatibility-mode indication |

## Verification
On every cycle the assertions check the following:
- The set and clear pulses never overlap and never appear without a flag write.
- The fixed one-bits of the composed reads are present.
- An armed strobe always flips the speed and disarms the switch, while an unarmed strobe leaves everything alone.
- speed_changed never lasts two cycles.
- compat_mode never falls.

Only the bench scenarios can show that the data values are right. These are the enable byte that reads back, the request pattern seen through the flag byte, the exact compatibility value that triggers the sticky mode, and the priority of a strobe over a same-cycle write.

// File: rtl/irq_speed_pkg.sv
package irq_speed_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    SEL_FLAG  = 2'd0,
    SEL_EN    = 2'd1,
    SEL_COMPAT= 2'd2,
    SEL_SPEED = 2'd3
  } reg_sel_e;

  function automatic logic [DW-1:0] flag_byte(input logic [4:0] req);
    return {3'b111, req};
  endfunction

  function automatic logic [DW-1:0] speed_byte(input logic dbl, input logic arm);
    return {dbl, 6'b111111, arm};
  endfunction
endpackage

// File: rtl/ctrl_regs_decode.sv
module ctrl_regs_decode #(
  parameter int AW = 16,
  parameter logic [AW-1:0] A_FLAG   = 16'hFF0F,
  parameter logic [AW-1:0] A_EN     = 16'hFFFF,
  parameter logic [AW-1:0] A_COMPAT = 16'hFF4C,
  parameter logic [AW-1:0] A_SPEED  = 16'hFF4D
) (
  input  logic [AW-1:0] addr,
  output logic [3:0]    sel
);
  localparam logic [AW-1:0] TABLE [4] = '{A_FLAG, A_EN, A_COMPAT, A_SPEED};
  for (genvar i = 0; i < 4; i++) begin : g_match
    assign sel[i] = (addr == TABLE[i]);
  end
endmodule

// File: rtl/irq_flag_port.sv
module irq_flag_port #(
  parameter int N = 5
) (
  input  logic         wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] set_p,
  output logic [N-1:0] clr_p
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign set_p[i] = wr &  wbits[i];
    assign clr_p[i] = wr & ~wbits[i];
  end
endmodule

// File: rtl/speed_ctrl.sv
module speed_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_arm,
  input  logic arm_val,
  input  logic exec,
  output logic dbl,
  output logic armed,
  output logic fire,
  output logic changed
);
  assign fire = exec & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbl     <= 1'b0;
      armed   <= 1'b0;
      changed <= 1'b0;
    end else begin
      changed <= fire;
      if (fire) begin
        dbl   <= ~dbl;
        armed <= 1'b0;
      end else if (wr_arm) begin
        armed <= arm_val;
      end
    end
  end
endmodule

// File: rtl/irq_speed_regs.sv
module irq_speed_regs
  import irq_speed_pkg::*;
#(
  parameter int AW    = 16,
  parameter int REQ_N = 5,
  parameter logic [AW-1:0] A_FLAG   = 16'hFF0F,
  parameter logic [AW-1:0] A_EN     = 16'hFFFF,
  parameter logic [AW-1:0] A_COMPAT = 16'hFF4C,
  parameter logic [AW-1:0] A_SPEED  = 16'hFF4D,
  parameter logic [7:0]    COMPAT_KEY = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             bus_rd_hit,
  input  logic [REQ_N-1:0] req_in,
  output logic [REQ_N-1:0] req_set,
  output logic [REQ_N-1:0] req_clr,
  output logic [7:0]       irq_enable,
  input  logic             spd_exec,
  output logic             double_speed,
  output logic             speed_changed,
  output logic             compat_mode
);
  logic [3:0] sel;
  logic [3:0] wsel;
  logic       armed;
  logic       exec_fire;
  logic [7:0] en_q;
  logic [7:0] compat_q;
  logic       compat_sticky_q;

  ctrl_regs_decode #(.AW(AW), .A_FLAG(A_FLAG), .A_EN(A_EN),
                     .A_COMPAT(A_COMPAT), .A_SPEED(A_SPEED)) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  assign wsel = sel & {4{bus_we}};

  irq_flag_port #(.N(REQ_N)) u_flag (
    .wr(wsel[SEL_FLAG]), .wbits(bus_wdata[REQ_N-1:0]),
    .set_p(req_set), .clr_p(req_clr)
  );

  speed_ctrl u_spd (
    .clk(clk), .rst_n(rst_n),
    .wr_arm(wsel[SEL_SPEED]), .arm_val(bus_wdata[0]),
    .exec(spd_exec),
    .dbl(double_speed), .armed(armed), .fire(exec_fire),
    .changed(speed_changed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q            <= '0;
      compat_q        <= '0;
      compat_sticky_q <= 1'b0;
    end else begin
      if (wsel[SEL_EN])     en_q <= bus_wdata;
      if (wsel[SEL_COMPAT]) begin
        compat_q <= bus_wdata;
        if (bus_wdata == COMPAT_KEY) compat_sticky_q <= 1'b1;
      end
    end
  end

  assign irq_enable  = en_q;
  assign compat_mode = compat_sticky_q;
  assign bus_rd_hit  = |sel;

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel[SEL_FLAG]:   bus_rdata = flag_byte(req_in);
      sel[SEL_EN]:     bus_rdata = en_q;
      sel[SEL_COMPAT]: bus_rdata = compat_q;
      sel[SEL_SPEED]:  bus_rdata = speed_byte(double_speed, armed);
      default:         bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_speed_regs_chk.sv
module irq_speed_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_we,
  input logic [7:0]  bus_rdata,
  input logic [4:0]  req_set,
  input logic [4:0]  req_clr,
  input logic        spd_exec,
  input logic        armed,
  input logic        double_speed,
  input logic        speed_changed,
  input logic        compat_mode
);
  assert_flag_read_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'hFF0F) |-> (bus_rdata[7:5] == 3'b111));

  assert_pulse_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_set & req_clr) == 5'b0);

  assert_pulse_only_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 16'hFF0F) |-> (req_set == 5'b0 && req_clr == 5'b0));

  assert_pulse_covers_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 16'hFF0F) |-> ((req_set | req_clr) == 5'h1F));

  assert_speed_read_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 16'hFF4D) |-> (bus_rdata[6:1] == 6'h3F));

  assert_armed_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_exec && armed) |=> (double_speed != $past(double_speed) && !armed && speed_changed));

  assert_change_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    speed_changed |=> !speed_changed);

  assert_unarmed_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_exec && !armed) |=> ($stable(double_speed) && !speed_changed));

  assert_compat_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    compat_mode |=> compat_mode);
endmodule

bind irq_speed_regs irq_speed_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .req_set(req_set), .req_clr(req_clr),
  .spd_exec(spd_exec), .armed(armed), .double_speed(double_speed),
  .speed_changed(speed_changed), .compat_mode(compat_mode)
);

// File: tb/sim_irq_speed_regs.sv
`timescale 1ns/1ps
module sim_irq_speed_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        bus_rd_hit;
  logic [4:0]  req_in = 5'h00;
  logic [4:0]  req_set, req_clr;
  logic [7:0]  irq_enable;
  logic        spd_exec = 1'b0;
  logic        double_speed, speed_changed, compat_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_en = 0, m_compat = 0, m_sticky = 0, m_armed = 0, m_dbl = 0, m_chg = 0;

  always #10 clk = ~clk;

  irq_speed_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_hit(bus_rd_hit),
    .req_in(req_in), .req_set(req_set), .req_clr(req_clr),
    .irq_enable(irq_enable), .spd_exec(spd_exec),
    .double_speed(double_speed), .speed_changed(speed_changed),
    .compat_mode(compat_mode)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic [15:0] a, input logic w,
                       input logic [7:0] d, input logic x, input logic [4:0] r);
    int exp_rd, exp_hit, exp_set, exp_clr, fire;
    string rtag;
    @(negedge clk);
    bus_addr = a; bus_we = w; bus_wdata = d; spd_exec = x; req_in = r;
    #2;
    exp_hit = 1; exp_set = 0; exp_clr = 0;
    case (a)
      16'hFF0F: begin exp_rd = 224 + r; rtag = "R1"; end
      16'hFFFF: begin exp_rd = m_en; rtag = "R3"; end
      16'hFF4C: begin exp_rd = m_compat; rtag = "R8"; end
      16'hFF4D: begin exp_rd = m_dbl * 128 + 126 + m_armed; rtag = "R5"; end
      default:  begin exp_rd = 0; exp_hit = 0; rtag = "R11"; end
    endcase
    if (w && a == 16'hFF0F) begin exp_set = d[4:0]; exp_clr = 31 - d[4:0]; end
    chk({tag, " ", rtag}, "rdata", bus_rdata, exp_rd);
    chk({tag, " ", rtag}, "rd_hit", bus_rd_hit, exp_hit);
    chk({tag, " R2"}, "req_set", req_set, exp_set);
    chk({tag, " R2"}, "req_clr", req_clr, exp_clr);
    chk({tag, " R3"}, "irq_enable", irq_enable, m_en);
    chk({tag, " R6"}, "double_speed", double_speed, m_dbl);
    chk({tag, " R6"}, "speed_changed", speed_changed, m_chg);
    chk({tag, " R8"}, "compat_mode", compat_mode, m_sticky);
    // next-state of the reference model
    fire = (x && m_armed) ? 1 : 0;
    if (w && a == 16'hFFFF) m_en = d;
    if (w && a == 16'hFF4C) begin m_compat = d; if (d == 8'h04) m_sticky = 1; end
    if (fire) begin m_dbl = 1 - m_dbl; m_armed = 0; end
    else if (w && a == 16'hFF4D) m_armed = d[0];
    m_chg = fire;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9: reset values seen through reads and outputs
    cycle("R9", 16'hFFFF, 0, 8'h00, 0, 5'h00);
    cycle("R9", 16'hFF4C, 0, 8'h00, 0, 5'h00);
    cycle("R9", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    // R1: composed flag byte under several request patterns
    cycle("R1", 16'hFF0F, 0, 8'h00, 0, 5'h00);
    cycle("R1", 16'hFF0F, 0, 8'h00, 0, 5'h15);
    cycle("R1", 16'hFF0F, 0, 8'h00, 0, 5'h1F);
    cycle("R1", 16'hFF0F, 0, 8'h00, 0, 5'h0A);
    // R2: flag writes produce set/clear pulses
    cycle("R2", 16'hFF0F, 1, 8'h0A, 0, 5'h00);
    cycle("R2", 16'hFF0F, 1, 8'hFF, 0, 5'h00);
    cycle("R2", 16'hFF0F, 1, 8'hE0, 0, 5'h00);
    cycle("R2", 16'hFF0F, 0, 8'h1F, 0, 5'h00);
    // R3: enable register
    cycle("R3", 16'hFFFF, 1, 8'hA5, 0, 5'h00);
    cycle("R3", 16'hFFFF, 0, 8'h00, 0, 5'h00);
    cycle("R3", 16'hFFFF, 1, 8'h5A, 0, 5'h00);
    cycle("R3", 16'hFFFF, 0, 8'h00, 0, 5'h00);
    // R7: unarmed execute is ignored
    cycle("R7", 16'hFF4D, 0, 8'h00, 1, 5'h00);
    cycle("R7", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    // R4: arm, then R6: execute
    cycle("R4", 16'hFF4D, 1, 8'hFF, 0, 5'h00);
    cycle("R4", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    cycle("R6", 16'hFF4D, 0, 8'h00, 1, 5'h00);
    cycle("R6", 16'hFF4D, 0, 8'h00, 1, 5'h00);
    cycle("R6", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    // R4: arm then disarm, execute ignored (R7)
    cycle("R4", 16'hFF4D, 1, 8'h01, 0, 5'h00);
    cycle("R4", 16'hFF4D, 1, 8'hFE, 0, 5'h00);
    cycle("R7", 16'hFF4D, 0, 8'h00, 1, 5'h00);
    cycle("R7", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    // R6: switch back to normal
    cycle("R6", 16'hFF4D, 1, 8'h01, 0, 5'h00);
    cycle("R6", 16'hFF4D, 0, 8'h00, 1, 5'h00);
    cycle("R6", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    // R10: armed strobe and arming write in the same cycle
    cycle("R10", 16'hFF4D, 1, 8'h01, 0, 5'h00);
    cycle("R10", 16'hFF4D, 1, 8'h01, 1, 5'h00);
    cycle("R10", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    cycle("R10", 16'hFF4D, 0, 8'h00, 1, 5'h00);
    cycle("R10", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    // R8: compatibility register and sticky output
    cycle("R8", 16'hFF4C, 1, 8'h03, 0, 5'h00);
    cycle("R8", 16'hFF4C, 1, 8'h84, 0, 5'h00);
    cycle("R8", 16'hFF4C, 1, 8'h04, 0, 5'h00);
    cycle("R8", 16'hFF4C, 1, 8'h00, 0, 5'h00);
    cycle("R8", 16'hFF4C, 0, 8'h00, 0, 5'h00);
    // R11: unmapped addresses neither respond nor change state
    cycle("R11", 16'hFF4E, 1, 8'h01, 0, 5'h1F);
    cycle("R11", 16'hFFFE, 1, 8'h77, 0, 5'h1F);
    cycle("R11", 16'hFF0E, 1, 8'hFF, 0, 5'h1F);
    cycle("R11", 16'h0F0F, 1, 8'h55, 0, 5'h1F);
    cycle("R11", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    cycle("R11", 16'hFFFF, 0, 8'h00, 0, 5'h00);
    cycle("R11", 16'hFF4C, 0, 8'h00, 0, 5'h00);
    // R9: reset mid-run clears state again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_en = 0; m_compat = 0; m_sticky = 0; m_armed = 0; m_dbl = 0; m_chg = 0;
    cycle("R9", 16'hFFFF, 0, 8'h00, 0, 5'h00);
    cycle("R9", 16'hFF4D, 0, 8'h00, 0, 5'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule